// File: doc/BRIEF.md
# Compare-and-Skip Condition Unit

This block decides, for the conditional instructions of a small 8-bit core, whether the next instruction is to be skipped. It also reports how many cycles the instruction costs. Each request carries an operation code, the accumulator value, a memory or immediate operand, a bit index, and a flag that says whether a memory target is RAM or a system register. From these the block computes the arithmetic result and where that result goes (nowhere, the accumulator or memory). It also produces any flag updates, the skip decision and the cycle count. The three instruction families it handles are equality compare, counting to zero, and single-bit test.

Requests arrive on a valid/ready stream, and results leave on a second valid/ready stream. A single register stage sits between them. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result shows on the output one cycle later and stays there, unchanged, until the consumer takes it with `out_ready`. While an undelivered result is held, the input refuses new work unless that result is being drained in the same cycle. This lets the stage pass one request per cycle under full flow. The producer must hold its request stable until it is accepted. Fetch, memory and register writes are left to the surrounding core.

Top module: `csk_unit`

## Requirements
- R1: Operation code 0 (compare-and-skip) gives result = (A − operand) mod 256 and destination 0 (none). It asserts the flag write enable with Z = (A == operand) and C = (A ≥ operand, carry meaning "no borrow"). It skips exactly when A equals the operand.
- R2: Operation codes 1 (increment) and 2 (decrement) give result = operand ± 1 modulo 256, with destination 1 (accumulator). They skip exactly when that result is zero, so 0xFF + 1 and 0x01 − 1 both skip.
- R3: Operation codes 3 (increment) and 4 (decrement) compute the same result as R2 but give destination 2 (memory). They skip exactly when the new memory value is zero.
- R4: The four increment/decrement operations (codes 1 to 4) never assert the flag write enable.
- R5: Operation code 5 skips when bit `in_bit` of the operand is 0, and code 6 skips when that bit is 1. Neither asserts the flag write enable, both give destination 0, and the result equals the operand.
- R6: Operation code 7 is a plain pass: no skip, destination 0, no flag write, result equals the operand, and cost 1.
- R7: The cycle count is 1, plus 1 when the skip is taken, plus 1 when the destination is memory and `in_ram` is 1.
- R8: A request is accepted when `in_valid` and `in_ready` are both high at a clock edge, and its result is valid from the next cycle. `in_ready` is high whenever `out_valid` is low or `out_ready` is high. `out_valid` goes low after a result is taken and no new request is accepted.
- R9: While `out_valid` is high and `out_ready` is low, every output field holds its value.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_op | input | 3 | Operation code (0..7, see R1–R6) |
| in_a | input | 8 | Accumulator value |
| in_opnd | input | 8 | Memory or immediate operand |
| in_bit | input | 3 | Bit index for bit-test operations |
| in_ram | input | 1 | Memory target is RAM (1) or a system register (0) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 8 | Computed value |
| out_dest | output | 2 | Destination: 0 none, 1 accumulator, 2 memory |
| out_flag_we | output | 1 | Z and C are to be written |
| out_zf | output | 1 | New zero flag (valid with flag write enable) |
| out_cf | output | 1 | New carry flag (valid with flag write enable) |
| out_skip | output | 1 | Skip the next instruction |
| out_cycles | output | 2 | Cycle cost, 1 to 3 |

## Verification
The properties assume the producer follows the stream rule: once `in_valid` is high, the request stays unchanged until it is accepted. They also assume reset is applied before the first request. The bench keeps an unaccepted request fixed across cycles and only draws a new one after acceptance. It varies `out_ready` at random to create back-pressure. All eight operation codes and every bit index are legal, so the random stimulus covers the full input space. A directed prologue aims at equality, wrap to zero, and RAM versus system-register targets.

// File: rtl/csk_pkg.sv
package csk_pkg;

  typedef enum logic [2:0] {
    OP_CMPSK   = 3'd0,
    OP_INCSK_A = 3'd1,
    OP_DECSK_A = 3'd2,
    OP_INCSK_M = 3'd3,
    OP_DECSK_M = 3'd4,
    OP_BTSK_LO = 3'd5,
    OP_BTSK_HI = 3'd6,
    OP_PASS    = 3'd7
  } csk_op_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_ACC  = 2'd1,
    DST_MEM  = 2'd2
  } csk_dst_e;

  localparam int CYC_W = 2;

endpackage

// File: rtl/csk_eval.sv
module csk_eval
  import csk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input  csk_op_e             op,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   opnd,
  input  logic [BIT_W-1:0]    bit_idx,
  output logic [DATA_W-1:0]   result,
  output csk_dst_e            dest,
  output logic                flag_we,
  output logic                zf,
  output logic                cf,
  output logic                res_zero,
  output logic                sel_bit
);

  logic [DATA_W:0]   diff;
  logic [DATA_W-1:0] inc_v;
  logic [DATA_W-1:0] dec_v;

  assign diff    = {1'b0, a} - {1'b0, opnd};
  assign inc_v   = opnd + {{(DATA_W-1){1'b0}}, 1'b1};
  assign dec_v   = opnd - {{(DATA_W-1){1'b0}}, 1'b1};
  assign sel_bit = opnd[bit_idx];

  always_comb begin
    result  = opnd;
    dest    = DST_NONE;
    flag_we = 1'b0;
    zf      = 1'b0;
    cf      = 1'b0;
    unique case (op)
      OP_CMPSK: begin
        result  = diff[DATA_W-1:0];
        flag_we = 1'b1;
        zf      = (diff[DATA_W-1:0] == '0);
        cf      = ~diff[DATA_W];
      end
      OP_INCSK_A: begin result = inc_v; dest = DST_ACC; end
      OP_DECSK_A: begin result = dec_v; dest = DST_ACC; end
      OP_INCSK_M: begin result = inc_v; dest = DST_MEM; end
      OP_DECSK_M: begin result = dec_v; dest = DST_MEM; end
      default: ;
    endcase
  end

  assign res_zero = (result == '0);

endmodule

// File: rtl/csk_skip_cost.sv
module csk_skip_cost
  import csk_pkg::*;
(
  input  csk_op_e          op,
  input  logic             res_zero,
  input  logic             sel_bit,
  input  csk_dst_e         dest,
  input  logic             is_ram,
  output logic             skip,
  output logic [CYC_W-1:0] cycles
);

  logic ram_wr;

  always_comb begin
    unique case (op)
      OP_CMPSK,
      OP_INCSK_A, OP_DECSK_A,
      OP_INCSK_M, OP_DECSK_M: skip = res_zero;
      OP_BTSK_LO:             skip = ~sel_bit;
      OP_BTSK_HI:             skip = sel_bit;
      default:                skip = 1'b0;
    endcase
  end

  assign ram_wr = (dest == DST_MEM) && is_ram;
  assign cycles = CYC_W'(1) + CYC_W'(skip) + CYC_W'(ram_wr);

endmodule

// File: rtl/csk_pipe_reg.sv
module csk_pipe_reg #(
  parameter int PAY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [PAY_W-1:0] s_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [PAY_W-1:0] m_data
);

  assign s_ready = ~m_valid | m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_data <= s_data;
    end
  end

endmodule

// File: rtl/csk_unit.sv
module csk_unit
  import csk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_opnd,
  input  logic [BIT_W-1:0]  in_bit,
  input  logic              in_ram,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [1:0]        out_dest,
  output logic              out_flag_we,
  output logic              out_zf,
  output logic              out_cf,
  output logic              out_skip,
  output logic [CYC_W-1:0]  out_cycles
);

  localparam int PAY_W = DATA_W + 2 + 3 + 1 + CYC_W;

  csk_op_e           op_c;
  logic [DATA_W-1:0] res_c;
  csk_dst_e          dst_c;
  logic              fwe_c, zf_c, cf_c, rz_c, bit_c, skip_c;
  logic [CYC_W-1:0]  cyc_c;
  logic [PAY_W-1:0]  pay_in, pay_out;

  assign op_c = csk_op_e'(in_op);

  csk_eval #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_eval (
    .op      (op_c),
    .a       (in_a),
    .opnd    (in_opnd),
    .bit_idx (in_bit),
    .result  (res_c),
    .dest    (dst_c),
    .flag_we (fwe_c),
    .zf      (zf_c),
    .cf      (cf_c),
    .res_zero(rz_c),
    .sel_bit (bit_c)
  );

  csk_skip_cost u_cost (
    .op      (op_c),
    .res_zero(rz_c),
    .sel_bit (bit_c),
    .dest    (dst_c),
    .is_ram  (in_ram),
    .skip    (skip_c),
    .cycles  (cyc_c)
  );

  assign pay_in = {res_c, dst_c, fwe_c, zf_c, cf_c, skip_c, cyc_c};

  csk_pipe_reg #(.PAY_W(PAY_W)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(in_valid),
    .s_ready(in_ready),
    .s_data (pay_in),
    .m_valid(out_valid),
    .m_ready(out_ready),
    .m_data (pay_out)
  );

  assign {out_result, out_dest, out_flag_we, out_zf, out_cf, out_skip, out_cycles} = pay_out;

endmodule

// File: rtl/csk_unit_chk.sv
module csk_unit_chk #(
  parameter int DATA_W = 8,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_op,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_opnd,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic [1:0]        out_dest,
  input logic              out_flag_we,
  input logic              out_zf,
  input logic              out_cf,
  input logic              out_skip,
  input logic [1:0]        out_cycles
);

  logic fire;
  assign fire = in_valid && in_ready;

  p_cmp_equal_skips_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == 3'd0 && in_a == in_opnd) |=> (out_valid && out_skip && out_flag_we && out_zf && out_cf));

  p_inc_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == 3'd1 && in_opnd == '1) |=> (out_skip && out_result == '0 && out_dest == 2'd1));

  p_mem_dest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (in_op == 3'd3 || in_op == 3'd4)) |=> (out_dest == 2'd2));

  p_counter_no_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op >= 3'd1 && in_op <= 3'd4) |=> !out_flag_we);

  p_bittest_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (in_op == 3'd5 || in_op == 3'd6)) |=> (!out_flag_we && out_dest == 2'd0 && out_result == $past(in_opnd)));

  p_min_cost_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_skip && out_dest != 2'd2) |-> (out_cycles == 2'd1));

  p_ready_when_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);

  p_drain_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && (!out_valid || out_ready)) |=> !out_valid);

  p_hold_under_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_dest)
      && $stable(out_skip) && $stable(out_cycles) && $stable(out_flag_we)));

endmodule

bind csk_unit csk_unit_chk #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .in_a       (in_a),
  .in_opnd    (in_opnd),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_dest   (out_dest),
  .out_flag_we(out_flag_we),
  .out_zf     (out_zf),
  .out_cf     (out_cf),
  .out_skip   (out_skip),
  .out_cycles (out_cycles)
);

// File: tb/tb_csk_unit.sv
module tb_csk_unit;

  localparam int CLK_PERIOD = 10;
  localparam int N_CYCLES   = 6000;

  typedef struct {
    int op; int a; int m; int b; int ram;
  } req_t;

  typedef struct {
    int op; int res; int dst; int fwe; int z; int c; int skip; int cyc;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_op = '0;
  logic [7:0] in_a = '0;
  logic [7:0] in_opnd = '0;
  logic [2:0] in_bit = '0;
  logic       in_ram = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_result;
  logic [1:0] out_dest;
  logic       out_flag_we, out_zf, out_cf, out_skip;
  logic [1:0] out_cycles;

  int   compared = 0;
  int   mismatched = 0;
  bit   done = 0;
  req_t dir_q[$];
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  csk_unit dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_opnd(in_opnd), .in_bit(in_bit), .in_ram(in_ram),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_dest(out_dest), .out_flag_we(out_flag_we),
    .out_zf(out_zf), .out_cf(out_cf), .out_skip(out_skip), .out_cycles(out_cycles)
  );

  task automatic chk(string tag, string what, int act, int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, expv, $time);
    end
  endtask

  function automatic exp_t model(req_t r);
    exp_t e;
    e.op = r.op; e.res = r.m; e.dst = 0; e.fwe = 0; e.z = 0; e.c = 0; e.skip = 0;
    case (r.op)
      0: begin
        e.res = (r.a - r.m) & 255; e.fwe = 1;
        e.z = (r.a == r.m); e.c = (r.a >= r.m); e.skip = (r.a == r.m);
      end
      1, 3: begin e.res = (r.m + 1) & 255; e.dst = (r.op == 1) ? 1 : 2; e.skip = (e.res == 0); end
      2, 4: begin e.res = (r.m + 255) & 255; e.dst = (r.op == 2) ? 1 : 2; e.skip = (e.res == 0); end
      5: e.skip = (((r.m >> r.b) & 1) == 0);
      6: e.skip = (((r.m >> r.b) & 1) == 1);
      default: ;
    endcase
    e.cyc = 1 + e.skip + ((e.dst == 2 && r.ram == 1) ? 1 : 0);
    return e;
  endfunction

  function automatic string op_tag(int op);
    case (op)
      0: return "R1";
      1, 2: return "R2";
      3, 4: return "R3";
      5, 6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check_out(exp_t e);
    string t;
    t = op_tag(e.op);
    chk(t, "result", int'(out_result), e.res);
    chk(t, "dest", int'(out_dest), e.dst);
    chk(t, "skip", int'(out_skip), e.skip);
    if (e.op >= 1 && e.op <= 4) chk("R4", "flag_we", int'(out_flag_we), 0);
    else chk(t, "flag_we", int'(out_flag_we), e.fwe);
    if (e.fwe == 1) begin
      chk("R1", "zf", int'(out_zf), e.z);
      chk("R1", "cf", int'(out_cf), e.c);
    end
    chk("R7", "cycles", int'(out_cycles), e.cyc);
  endtask

  task automatic add_dir(int op, int a, int m, int b, int ram);
    req_t r;
    r.op = op; r.a = a; r.m = m; r.b = b; r.ram = ram;
    dir_q.push_back(r);
  endtask

  function automatic req_t rand_req();
    req_t r;
    r.op = int'($urandom_range(0, 7));
    r.a = int'($urandom_range(0, 255));
    case ($urandom_range(0, 5))
      0: r.m = r.a;
      1: r.m = 255;
      2: r.m = 1;
      3: r.m = 0;
      default: r.m = int'($urandom_range(0, 255));
    endcase
    r.b = int'($urandom_range(0, 7));
    r.ram = int'($urandom_range(0, 1));
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    req_t cur;
    bit   pend;
    bit   fin, fout;
    int   stall;
    add_dir(0, 8'h5A, 8'h5A, 0, 0);
    add_dir(0, 8'h10, 8'h20, 0, 0);
    add_dir(0, 8'h20, 8'h10, 0, 0);
    add_dir(1, 0, 8'hFF, 0, 0);
    add_dir(2, 0, 8'h01, 0, 1);
    add_dir(2, 0, 8'h00, 0, 1);
    add_dir(3, 0, 8'hFF, 0, 1);
    add_dir(3, 0, 8'hFF, 0, 0);
    add_dir(4, 0, 8'h01, 0, 1);
    add_dir(4, 0, 8'h07, 0, 1);
    add_dir(5, 0, 8'h7F, 7, 0);
    add_dir(6, 0, 8'h80, 7, 0);
    add_dir(5, 0, 8'h01, 0, 0);
    add_dir(6, 0, 8'hFE, 0, 1);
    add_dir(7, 8'h33, 8'hC4, 3, 1);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "out_valid", int'(out_valid), 0);
    chk("R10", "in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "out_valid", int'(out_valid), 0);
    chk("R10", "in_ready", int'(in_ready), 1);

    pend = 0;
    stall = 0;
    for (int cyc = 0; cyc < N_CYCLES; cyc++) begin
      @(negedge clk);
      if (!pend) begin
        if (dir_q.size() > 0 && cyc > 4) begin
          cur = dir_q.pop_front();
          in_valid = 1'b1;
        end else begin
          cur = rand_req();
          in_valid = (cyc > 4) && ($urandom_range(0, 4) != 0);
        end
        in_op = 3'(cur.op); in_a = 8'(cur.a); in_opnd = 8'(cur.m);
        in_bit = 3'(cur.b); in_ram = cur.ram[0];
      end
      if (cyc >= 20 && cyc < 30) out_ready = 1'b0;
      else out_ready = ($urandom_range(0, 3) != 0);
      #1;
      chk("R8", "out_valid", int'(out_valid), (exp_q.size() != 0) ? 1 : 0);
      chk("R8", "in_ready", int'(in_ready), (exp_q.size() == 0 || out_ready) ? 1 : 0);
      if (out_valid && exp_q.size() != 0) begin
        if (!out_ready) stall++;
        check_out(exp_q[0]);
      end
      fin  = in_valid && in_ready;
      fout = out_valid && out_ready;
      if (fout && exp_q.size() != 0) void'(exp_q.pop_front());
      if (fin) exp_q.push_back(model(cur));
      pend = in_valid && !fin;
    end
    if (stall == 0) chk("R9", "stall cycles seen", 0, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule